// File: doc/BRIEF.md
# Accumulator Subtract, Test and Transfer Execution Unit

This unit executes a narrow slice of an 8-bit accumulator machine's instruction set: subtracting a memory byte from the accumulator (six address forms), testing a byte for sign and zero (memory, accumulator or index register), and copying between the accumulator and the index register. An opcode is handed over on a valid/ready handshake together with the current accumulator, index and condition-code values, which the unit samples at that moment. Operands that live in memory, including the immediate byte, arrive later on a second valid/ready handshake. Address generation happens outside the block.

Each opcode owns a fixed clock budget. The unit counts it out and raises `done` in the last clock of that budget. The updated accumulator, index and condition codes appear on the outputs at the clock edge that ends that cycle. An opcode outside the supported set produces a one-clock `illegal` pulse and leaves every output untouched.

Condition-code layout on `ccr_in`/`ccr_out`: bit 0 carry/borrow (C), bit 1 zero (Z), bit 2 negative (N), bit 3 interrupt mask, bit 4 half carry. Bits 7:5 pass through unchanged.

Top module: `acc_exec_unit`

## Requirements
- R1: After synchronous reset, `acc_out`, `idx_out` and `ccr_out` are 0x00, `op_ready` is 1, and `done`, `illegal` and `mem_ready` are 0.
- R2: Subtract opcodes and their clock budgets are 0xA0 immediate 2, 0xB0 direct 3, 0xC0 extended 4, 0xD0 16-bit-offset indexed 5, 0xE0 8-bit-offset indexed 4 and 0xF0 no-offset indexed 3. Call the accept cycle cycle 0. If the operand is offered from cycle 1 on, `done` is high in cycle budget−1 and low in every earlier cycle.
- R3: Subtract loads the accumulator with (A − M) mod 256 and sets N to bit 7 of the result. Z is set when the result is zero. C is set exactly when M > A as unsigned values. All other condition bits and the index register keep their sampled values.
- R4: Memory test opcodes are 0x3D direct with budget 4, 0x6D 8-bit-offset indexed with budget 5 and 0x7D no-offset indexed with budget 4. They set N and Z from the operand. C, the other condition bits, the accumulator and the index register keep their sampled values.
- R5: 0x4D tests the accumulator and 0x5D tests the index register, each with budget 3. Neither requests an operand (`mem_ready` stays 0). Flags are set as in R4.
- R6: 0x97 copies the accumulator to the index register and 0x9F copies the index register to the accumulator, each with budget 2. The condition codes keep their sampled value.
- R7: An accepted opcode outside R2, R4, R5 and R6 raises `illegal` in the next cycle only. It starts no instruction, leaves all outputs unchanged, and `op_ready` stays 1.
- R8: `op_ready` is 0 from the cycle after acceptance up to and including the `done` cycle. It is 1 in the cycle after `done`. An opcode offered while busy is neither accepted nor flagged.
- R9: `mem_ready` is high only for operand-using opcodes, from cycle 1 until the operand is taken. If the operand arrives late, `done` waits and rises no earlier than the cycle in which `mem_valid` is first high.
- R10: `acc_out`, `idx_out` and `ccr_out` change only at the clock edge that ends a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode offered |
| op_ready | output | 1 | Unit idle and able to take an opcode |
| op_code | input | 8 | Opcode byte |
| acc_in | input | 8 | Accumulator value sampled at acceptance |
| idx_in | input | 8 | Index register value sampled at acceptance |
| ccr_in | input | 8 | Condition codes sampled at acceptance |
| mem_valid | input | 1 | Operand byte offered |
| mem_ready | output | 1 | Unit waiting for the operand |
| mem_data | input | 8 | Operand byte |
| done | output | 1 | Last clock of the instruction's budget |
| illegal | output | 1 | One-clock pulse for an unsupported opcode |
| acc_out | output | 8 | Updated accumulator |
| idx_out | output | 8 | Updated index register |
| ccr_out | output | 8 | Updated condition codes |

## Verification
Numbering the acceptance clock as cycle 0, `done` is due in cycle budget−1, or in the first later cycle in which the operand is offered. The new register values are due one edge after that cycle, and `illegal` is due exactly one cycle after an unsupported opcode is accepted. The bench drives inputs on the falling edge and samples one time unit later. In every clock it compares `done`, `op_ready`, `mem_ready`, `illegal` and the three register outputs against a behavioural model that counts cycles from acceptance. It therefore catches both an early or late strobe and any output change outside the edge that ends a `done` cycle. Operand delays are varied to exercise the stall path, and junk opcodes are held on the input while the unit is busy.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

    localparam int DW   = 8;
    localparam int CW   = 3;
    localparam int C_BIT = 0;
    localparam int Z_BIT = 1;
    localparam int N_BIT = 2;

    typedef enum logic [1:0] {K_SUB, K_TST, K_TAX, K_TXA} kind_e;
    typedef enum logic [1:0] {S_MEM, S_ACC, S_IDX} src_e;

    typedef struct packed {
        logic          legal;
        kind_e         kind;
        src_e          src;
        logic [CW-1:0] budget;
    } dec_t;

    function automatic dec_t make_dec(input kind_e k, input src_e s, input int b);
        dec_t d;
        d.legal  = 1'b1;
        d.kind   = k;
        d.src    = s;
        d.budget = CW'(b);
        return d;
    endfunction

    function automatic dec_t decode(input logic [7:0] op);
        dec_t d;
        d = '{legal: 1'b0, kind: K_SUB, src: S_MEM, budget: '0};
        case (op)
            8'hA0: d = make_dec(K_SUB, S_MEM, 2);
            8'hB0: d = make_dec(K_SUB, S_MEM, 3);
            8'hC0: d = make_dec(K_SUB, S_MEM, 4);
            8'hD0: d = make_dec(K_SUB, S_MEM, 5);
            8'hE0: d = make_dec(K_SUB, S_MEM, 4);
            8'hF0: d = make_dec(K_SUB, S_MEM, 3);
            8'h3D: d = make_dec(K_TST, S_MEM, 4);
            8'h4D: d = make_dec(K_TST, S_ACC, 3);
            8'h5D: d = make_dec(K_TST, S_IDX, 3);
            8'h6D: d = make_dec(K_TST, S_MEM, 5);
            8'h7D: d = make_dec(K_TST, S_MEM, 4);
            8'h97: d = make_dec(K_TAX, S_ACC, 2);
            8'h9F: d = make_dec(K_TXA, S_IDX, 2);
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/acc_exec_seq.sv
module acc_exec_seq
    import acc_exec_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic          dec_legal,
    input  logic          dec_mem,
    input  logic [CW-1:0] dec_budget,
    input  logic          mem_valid,
    input  logic [DW-1:0] mem_data,
    output logic          op_ready,
    output logic          accept,
    output logic          mem_ready,
    output logic          done,
    output logic          illegal,
    output logic [DW-1:0] operand
);
    logic          busy_q, need_q, have_q, illegal_q;
    logic [CW-1:0] cnt_q, last_q;
    logic [DW-1:0] opnd_q;
    logic          opnd_avail;

    assign op_ready   = !busy_q;
    assign accept     = op_valid && op_ready;
    assign mem_ready  = busy_q && need_q && !have_q;
    assign opnd_avail = !need_q || have_q || mem_valid;
    assign done       = busy_q && (cnt_q == last_q) && opnd_avail;
    assign operand    = have_q ? opnd_q : mem_data;
    assign illegal    = illegal_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            need_q    <= 1'b0;
            have_q    <= 1'b0;
            illegal_q <= 1'b0;
            cnt_q     <= '0;
            last_q    <= '0;
            opnd_q    <= '0;
        end else begin
            illegal_q <= accept && !dec_legal;
            if (accept) begin
                busy_q <= dec_legal;
                need_q <= dec_mem;
                have_q <= 1'b0;
                cnt_q  <= CW'(1);
                last_q <= dec_budget - CW'(1);
            end else if (busy_q) begin
                if (done) busy_q <= 1'b0;
                if (cnt_q != last_q) cnt_q <= cnt_q + CW'(1);
                if (mem_valid && mem_ready) begin
                    have_q <= 1'b1;
                    opnd_q <= mem_data;
                end
            end
        end
    end

    p_ready_after_done_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> op_ready);
    p_illegal_source_r7: assert property (@(posedge clk) disable iff (rst)
        illegal |-> $past(op_valid && op_ready) && op_ready);
    p_memready_busy_r9: assert property (@(posedge clk) disable iff (rst)
        mem_ready |-> !op_ready && !illegal);
    p_done_needs_opnd_r9: assert property (@(posedge clk) disable iff (rst)
        (done && need_q && !have_q) |-> mem_valid);
endmodule

// File: rtl/acc_exec_alu.sv
module acc_exec_alu
    import acc_exec_pkg::*;
(
    input  kind_e         kind,
    input  src_e          src,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] idx,
    input  logic [DW-1:0] ccr,
    input  logic [DW-1:0] opnd,
    output logic [DW-1:0] acc_n,
    output logic [DW-1:0] idx_n,
    output logic [DW-1:0] ccr_n
);
    logic [DW:0]   diff;
    logic [DW-1:0] tval;

    always_comb begin
        diff  = {1'b0, acc} - {1'b0, opnd};
        acc_n = acc;
        idx_n = idx;
        ccr_n = ccr;
        case (src)
            S_ACC:   tval = acc;
            S_IDX:   tval = idx;
            default: tval = opnd;
        endcase
        case (kind)
            K_SUB: begin
                acc_n        = diff[DW-1:0];
                ccr_n[N_BIT] = diff[DW-1];
                ccr_n[Z_BIT] = (diff[DW-1:0] == '0);
                ccr_n[C_BIT] = diff[DW];
            end
            K_TST: begin
                ccr_n[N_BIT] = tval[DW-1];
                ccr_n[Z_BIT] = (tval == '0);
            end
            K_TAX: idx_n = acc;
            K_TXA: acc_n = idx;
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
    import acc_exec_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    output logic          op_ready,
    input  logic [7:0]    op_code,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] idx_in,
    input  logic [DW-1:0] ccr_in,
    input  logic          mem_valid,
    output logic          mem_ready,
    input  logic [DW-1:0] mem_data,
    output logic          done,
    output logic          illegal,
    output logic [DW-1:0] acc_out,
    output logic [DW-1:0] idx_out,
    output logic [DW-1:0] ccr_out
);
    dec_t          dec, dec_q;
    logic          accept;
    logic [DW-1:0] acc_q, idx_q, ccr_q, operand;
    logic [DW-1:0] acc_n, idx_n, ccr_n;

    assign dec = decode(op_code);

    acc_exec_seq u_seq (
        .clk(clk), .rst(rst), .op_valid(op_valid),
        .dec_legal(dec.legal), .dec_mem(dec.src == S_MEM),
        .dec_budget(dec.budget), .mem_valid(mem_valid), .mem_data(mem_data),
        .op_ready(op_ready), .accept(accept), .mem_ready(mem_ready),
        .done(done), .illegal(illegal), .operand(operand)
    );

    acc_exec_alu u_alu (
        .kind(dec_q.kind), .src(dec_q.src), .acc(acc_q), .idx(idx_q),
        .ccr(ccr_q), .opnd(operand),
        .acc_n(acc_n), .idx_n(idx_n), .ccr_n(ccr_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q   <= '{legal: 1'b0, kind: K_SUB, src: S_MEM, budget: '0};
            acc_q   <= '0;
            idx_q   <= '0;
            ccr_q   <= '0;
            acc_out <= '0;
            idx_out <= '0;
            ccr_out <= '0;
        end else begin
            if (accept && dec.legal) begin
                dec_q <= dec;
                acc_q <= acc_in;
                idx_q <= idx_in;
                ccr_q <= ccr_in;
            end
            if (done) begin
                acc_out <= acc_n;
                idx_out <= idx_n;
                ccr_out <= ccr_n;
            end
        end
    end

    // checker: cycles elapsed since acceptance
    logic [CW+3:0] elapsed_q;
    always_ff @(posedge clk) begin
        if (rst)                             elapsed_q <= '0;
        else if (accept)                     elapsed_q <= 1;
        else if (elapsed_q != '1 && !op_ready) elapsed_q <= elapsed_q + 1'b1;
    end

    p_budget_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> elapsed_q >= ({3'b0, dec_q.budget} - 1));
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(acc_out) && $stable(idx_out) && $stable(ccr_out));
    p_sub_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (done && dec_q.kind == K_SUB) |=>
            ccr_out[7:3] == $past(ccr_q[7:3]) && idx_out == $past(idx_q));
    p_tst_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (done && dec_q.kind == K_TST) |=>
            ccr_out[C_BIT] == $past(ccr_q[C_BIT]) && acc_out == $past(acc_q));
    p_tax_r6: assert property (@(posedge clk) disable iff (rst)
        (done && dec_q.kind == K_TAX) |=>
            idx_out == $past(acc_q) && ccr_out == $past(ccr_q));
endmodule

// File: tb/acc_exec_unit_tb.sv
module acc_exec_unit_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0, mem_valid = 1'b0;
    logic [7:0] op_code = '0, acc_in = '0, idx_in = '0, ccr_in = '0, mem_data = '0;
    logic       op_ready, mem_ready, done, illegal;
    logic [7:0] acc_out, idx_out, ccr_out;

    int total = 0, bad = 0;
    logic finished = 1'b0;
    logic [7:0] m_acc = 0, m_idx = 0, m_ccr = 0;

    always #2.5 clk = ~clk;

    acc_exec_unit u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
        .op_code(op_code), .acc_in(acc_in), .idx_in(idx_in), .ccr_in(ccr_in),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_data(mem_data),
        .done(done), .illegal(illegal), .acc_out(acc_out), .idx_out(idx_out),
        .ccr_out(ccr_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        chk(acc_out == m_acc, req, acc_out, m_acc);
        chk(idx_out == m_idx, req, idx_out, m_idx);
        chk(ccr_out == m_ccr, req, ccr_out, m_ccr);
    endtask

    // returns budget, memory flag, kind (0 sub,1 tst mem,2 tsta,3 tstx,4 tax,5 txa)
    function automatic int info(input logic [7:0] op, output bit mem, output int kind);
        mem = 1'b1; kind = 0;
        case (op)
            8'hA0: return 2; 8'hB0: return 3; 8'hC0: return 4;
            8'hD0: return 5; 8'hE0: return 4; 8'hF0: return 3;
            8'h3D: begin kind = 1; return 4; end
            8'h6D: begin kind = 1; return 5; end
            8'h7D: begin kind = 1; return 4; end
            8'h4D: begin kind = 2; mem = 0; return 3; end
            8'h5D: begin kind = 3; mem = 0; return 3; end
            8'h97: begin kind = 4; mem = 0; return 2; end
            8'h9F: begin kind = 5; mem = 0; return 2; end
            default: begin kind = -1; mem = 0; return 0; end
        endcase
    endfunction

    task automatic run(input logic [7:0] op, input logic [7:0] a, input logic [7:0] x,
                       input logic [7:0] c, input logic [7:0] m, input int delay,
                       input bit junk, input string req);
        bit mem, cap;
        int kind, len, k, diff;
        logic [7:0] t, r, nc;
        len = info(op, mem, kind);
        @(negedge clk);
        op_valid = 1; op_code = op; acc_in = a; idx_in = x; ccr_in = c;
        #1 chk(op_ready == 1, "R8 ready before accept", op_ready, 1);
        @(negedge clk);
        op_valid = junk; op_code = 8'h00;
        acc_in = 8'h5A; idx_in = 8'hA5; ccr_in = 8'hFF;
        cap = 0; k = 1;
        forever begin
            mem_valid = mem && !cap && (k >= 1 + delay);
            mem_data  = mem_valid ? m : 8'hEE;
            #1;
            chk(done == ((k >= len - 1) && (!mem || cap || mem_valid)), req, done, k);
            chk(op_ready == 0, "R8 busy", op_ready, 0);
            chk(illegal == 0, "R8 no flag while busy", illegal, 0);
            chk(mem_ready == (mem && !cap), "R9 mem_ready", mem_ready, mem && !cap);
            chk_regs("R10 hold while busy");
            if (done || k > 40) break;
            cap = cap || (mem_valid && mem_ready);
            @(negedge clk);
            k++;
        end
        @(negedge clk);
        mem_valid = 0; op_valid = 0;
        m_acc = a; m_idx = x; m_ccr = c;
        diff = int'(a) - int'(m);
        r = 8'(diff);
        case (kind)
            0: begin m_acc = r; nc = c; nc[2] = r[7]; nc[1] = (r == 0); nc[0] = (m > a); m_ccr = nc; end
            1, 2, 3: begin
                t = (kind == 1) ? m : (kind == 2) ? a : x;
                nc = c; nc[2] = t[7]; nc[1] = (t == 0); m_ccr = nc;
            end
            4: m_idx = a;
            5: m_acc = x;
            default: ;
        endcase
        #1;
        chk_regs(req);
        chk(op_ready == 1 && done == 0, "R8 ready after done", op_ready, 1);
    endtask

    task automatic bad_op(input logic [7:0] op);
        @(negedge clk);
        op_valid = 1; op_code = op; acc_in = 8'h11; idx_in = 8'h22; ccr_in = 8'h33;
        @(negedge clk);
        op_valid = 0;
        #1;
        chk(illegal == 1, "R7 pulse", illegal, 1);
        chk(op_ready == 1 && mem_ready == 0, "R7 no start", op_ready, 1);
        chk_regs("R7 unchanged");
        @(negedge clk);
        #1;
        chk(illegal == 0, "R7 single clock", illegal, 0);
        chk(done == 0, "R7 no done", done, 0);
        chk_regs("R7 unchanged later");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk(acc_out == 0 && idx_out == 0 && ccr_out == 0, "R1 regs", acc_out, 0);
        chk(op_ready == 1 && done == 0 && illegal == 0 && mem_ready == 0, "R1 ctrl", op_ready, 1);
        // R2 / R3: subtract in all modes
        run(8'hA0, 8'h10, 8'h01, 8'hF8, 8'h20, 0, 0, "R2 R3 sub imm borrow");
        run(8'hB0, 8'h44, 8'h02, 8'h07, 8'h44, 0, 0, "R2 R3 sub dir zero");
        run(8'hC0, 8'h80, 8'h03, 8'h18, 8'h01, 0, 1, "R2 R3 sub ext");
        run(8'hD0, 8'hFF, 8'h04, 8'h00, 8'h0F, 0, 0, "R2 R3 sub ix2");
        run(8'hE0, 8'h00, 8'h05, 8'h1F, 8'hFF, 0, 0, "R2 R3 sub ix1");
        run(8'hF0, 8'h7F, 8'h06, 8'hE0, 8'h80, 0, 0, "R2 R3 sub ix");
        // R9: late operand stalls
        run(8'hB0, 8'h30, 8'h07, 8'h00, 8'h10, 4, 0, "R9 late operand");
        run(8'hA0, 8'h05, 8'h08, 8'h01, 8'h05, 2, 1, "R9 late imm");
        // R4 / R5 tests
        run(8'h3D, 8'h12, 8'h34, 8'h01, 8'h80, 0, 0, "R4 tst dir neg");
        run(8'h6D, 8'h12, 8'h34, 8'h06, 8'h00, 1, 0, "R4 tst ix1 zero");
        run(8'h7D, 8'h12, 8'h34, 8'h1B, 8'h7F, 0, 0, "R4 tst ix pos");
        run(8'h4D, 8'h00, 8'h99, 8'h05, 8'h00, 0, 1, "R5 tsta zero");
        run(8'h5D, 8'h01, 8'h9C, 8'h03, 8'h00, 0, 0, "R5 tstx neg");
        // R6 transfers
        run(8'h97, 8'hC3, 8'h11, 8'h17, 8'h00, 0, 0, "R6 tax");
        run(8'h9F, 8'h22, 8'h00, 8'hE5, 8'h00, 0, 1, "R6 txa");
        // R7 illegal
        bad_op(8'h00);
        bad_op(8'h9D);
        run(8'hF0, 8'h09, 8'h44, 8'h00, 8'h0A, 0, 0, "R3 after illegal");
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule